// File: doc/BRIEF.md
# Vector Lane Predicate Mask Generator

This combinational block produces the active-lane mask for a 128-bit vector datapath. The mask holds one bit per byte lane, and a 1 marks a lane that may be written. Three independent sources each contribute a cut, and the block merges them:

- **Predicate with block enables.** A per-lane predicate word is paired with two 4-bit block-enable fields, one for each half of the vector. A half whose enable field is zero ignores the predicate and counts as fully active.
- **Tail cut-off.** On the last iteration of a counted loop, only the lanes belonging to the remaining elements stay active.
- **Beat cut-off.** When an interrupted instruction resumes, the beats it had already finished are switched off.

Consumers with wider elements read a sparse subset of the mask. A 16-bit element reads every second bit, starting at bit 0. A 32-bit element reads bits 0, 4, 8 and 12. The block itself always emits the full byte-lane mask.

The instruction sequencer drives this block every cycle from its architectural state. A beat code that cannot occur raises an illegal-state flag, which the sequencer can turn into a fault.

Top module: `pm_lane_mask`

## Requirements
- R1: When both block-enable fields (`blk_lo`, `blk_hi`) are nonzero and neither cut applies, `lane_mask` equals `pred_lanes`.
- R2: When `blk_lo` is zero, bits 7:0 of the merged predicate are all ones, whatever `pred_lanes[7:0]` holds.
- R3: When `blk_hi` is zero, bits 15:8 of the merged predicate are all ones, whatever `pred_lanes[15:8]` holds.
- R4: The tail cut applies when `tail_size` (element size code: 0 = byte, 1 = halfword, 2 = word, 3 = doubleword) is below 4 and `loop_cnt` is at most 16 >> `tail_size`. When it applies, only the low (`loop_cnt` << `tail_size`) mask bits survive. A count of zero clears the whole mask.
- R5: A `tail_size` of 4 or more, or a `loop_cnt` above 16 >> `tail_size`, leaves the mask untouched by the tail cut.
- R6: The beat cut is evaluated only when `exec_state[3:0]` is zero. Otherwise it has no effect and `illegal` is 0.
- R7: The beat code is `exec_state[7:4]` and clears low lanes as follows:
  - 0 clears nothing.
  - 1 clears bits 3:0.
  - 2 clears bits 7:0.
  - 4 and 5 both clear bits 11:0.
- R8: Any other beat code, while the beat cut is evaluated, sets `illegal` to 1 and drives `lane_mask` to all zeros.
- R9: `lane_mask` is the bitwise AND of the merged predicate, the tail cut and the beat cut, so all three can act together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pred_lanes | input | 16 | Per-byte-lane predicate word |
| blk_lo | input | 4 | Block-enable field for lanes 7:0 (zero = half fully active) |
| blk_hi | input | 4 | Block-enable field for lanes 15:8 (zero = half fully active) |
| tail_size | input | 3 | Tail element size code (4 or more = tail cut off) |
| loop_cnt | input | 32 | Remaining loop element count |
| exec_state | input | 8 | Execution state: condition bits [3:0], beat code [7:4] |
| lane_mask | output | 16 | Active byte-lane mask |
| illegal | output | 1 | Unreachable beat code seen |

## Verification
The case most likely to hide an error is a resumed instruction on its final loop iteration. In that case the tail cut and the beat cut act in the same evaluation, and a wrong merge order or an OR in place of an AND shows up only there. A directed task sets a small loop count together with each legal beat code and checks that only the lanes that both cuts allow remain. A sweep across size codes, counts around the tail limit, every beat code and both enable settings then compares each result against a reference model written in the bench.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int unsigned PM_LANES   = 16;
  localparam int unsigned PM_SIZE_W  = 3;
  localparam int unsigned PM_CNT_W   = 32;
  localparam int unsigned PM_XS_W    = 8;
  localparam int unsigned PM_BLK_W   = 4;
  localparam int unsigned PM_COND_W  = 4;

  typedef enum logic [3:0] {
    BEAT_NONE  = 4'd0,
    BEAT_ONE   = 4'd1,
    BEAT_TWO   = 4'd2,
    BEAT_THREE = 4'd4,
    BEAT_THREE_PLUS = 4'd5
  } beat_e;
endpackage

// File: rtl/pm_enable_merge.sv
module pm_enable_merge #(
  parameter int unsigned LANES = 16,
  parameter int unsigned BLK_W = 4
) (
  input  logic [LANES-1:0] pred,
  input  logic [BLK_W-1:0] blk_lo,
  input  logic [BLK_W-1:0] blk_hi,
  output logic [LANES-1:0] merged
);
  localparam int unsigned HALF = LANES / 2;

  logic lo_off;
  logic hi_off;

  assign lo_off = (blk_lo == '0);
  assign hi_off = (blk_hi == '0);

  // Each half either follows the predicate or is forced active
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i < HALF) begin : g_lo
      assign merged[i] = pred[i] | lo_off;
    end else begin : g_hi
      assign merged[i] = pred[i] | hi_off;
    end
  end
endmodule

// File: rtl/pm_tail_cut.sv
module pm_tail_cut #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned CNT_W  = 32
) (
  input  logic [SIZE_W-1:0] size_code,
  input  logic [CNT_W-1:0]  loop_cnt,
  output logic [LANES-1:0]  keep
);
  localparam int unsigned LOG_L = $clog2(LANES);
  localparam int unsigned LEN_W = LOG_L + 1;

  logic              active;
  logic [CNT_W-1:0]  limit;
  logic [LEN_W-1:0]  keep_len;

  always_comb begin
    limit    = CNT_W'(LANES) >> size_code;
    active   = (size_code < SIZE_W'(LOG_L)) && (loop_cnt <= limit);
    // Only meaningful when active: count <= LANES >> size, product <= LANES
    keep_len = LEN_W'(loop_cnt[LEN_W-1:0] << size_code);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign keep[i] = !active || (LEN_W'(i) < keep_len);
  end
endmodule

// File: rtl/pm_beat_cut.sv
module pm_beat_cut
  import pm_pkg::*;
#(
  parameter int unsigned LANES  = 16,
  parameter int unsigned XS_W   = 8,
  parameter int unsigned COND_W = 4
) (
  input  logic [XS_W-1:0]  exec_state,
  output logic [LANES-1:0] keep,
  output logic             illegal
);
  localparam int unsigned CODE_W     = XS_W - COND_W;
  localparam int unsigned BEAT_LANES = LANES / 4;
  localparam int unsigned DONE_W     = 2;

  logic              check_on;
  logic [CODE_W-1:0] code;
  logic [DONE_W-1:0] done_beats;
  logic              bad_code;

  assign check_on = (exec_state[COND_W-1:0] == '0);
  assign code     = exec_state[XS_W-1:COND_W];

  always_comb begin
    done_beats = '0;
    bad_code   = 1'b0;
    case (code)
      CODE_W'(BEAT_NONE):       done_beats = 2'd0;
      CODE_W'(BEAT_ONE):        done_beats = 2'd1;
      CODE_W'(BEAT_TWO):        done_beats = 2'd2;
      CODE_W'(BEAT_THREE),
      CODE_W'(BEAT_THREE_PLUS): done_beats = 2'd3;
      default:                  bad_code   = 1'b1;
    endcase
  end

  assign illegal = check_on && bad_code;

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    localparam int unsigned BEAT_IDX = i / BEAT_LANES;
    assign keep[i] = !check_on ||
                     (!bad_code && (DONE_W'(BEAT_IDX) >= done_beats));
  end
endmodule

// File: rtl/pm_lane_mask.sv
module pm_lane_mask
  import pm_pkg::*;
#(
  parameter int unsigned LANES  = PM_LANES,
  parameter int unsigned BLK_W  = PM_BLK_W,
  parameter int unsigned SIZE_W = PM_SIZE_W,
  parameter int unsigned CNT_W  = PM_CNT_W,
  parameter int unsigned XS_W   = PM_XS_W
) (
  input  logic [LANES-1:0]  pred_lanes,
  input  logic [BLK_W-1:0]  blk_lo,
  input  logic [BLK_W-1:0]  blk_hi,
  input  logic [SIZE_W-1:0] tail_size,
  input  logic [CNT_W-1:0]  loop_cnt,
  input  logic [XS_W-1:0]   exec_state,
  output logic [LANES-1:0]  lane_mask,
  output logic              illegal
);
  logic [LANES-1:0] merged;
  logic [LANES-1:0] tail_keep;
  logic [LANES-1:0] beat_keep;

  pm_enable_merge #(.LANES(LANES), .BLK_W(BLK_W)) u_merge (
    .pred   (pred_lanes),
    .blk_lo (blk_lo),
    .blk_hi (blk_hi),
    .merged (merged)
  );

  pm_tail_cut #(.LANES(LANES), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_tail (
    .size_code (tail_size),
    .loop_cnt  (loop_cnt),
    .keep      (tail_keep)
  );

  pm_beat_cut #(.LANES(LANES), .XS_W(XS_W), .COND_W(PM_COND_W)) u_beat (
    .exec_state (exec_state),
    .keep       (beat_keep),
    .illegal    (illegal)
  );

  assign lane_mask = merged & tail_keep & beat_keep;
endmodule

// File: rtl/pm_lane_mask_chk.sv
module pm_lane_mask_chk #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned BLK_W  = 4,
  parameter int unsigned SIZE_W = 3,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned XS_W   = 8
) (
  input logic [LANES-1:0]  pred_lanes,
  input logic [BLK_W-1:0]  blk_lo,
  input logic [BLK_W-1:0]  blk_hi,
  input logic [SIZE_W-1:0] tail_size,
  input logic [CNT_W-1:0]  loop_cnt,
  input logic [XS_W-1:0]   exec_state,
  input logic [LANES-1:0]  lane_mask,
  input logic              illegal
);
  logic no_tail;
  logic no_beat;
  assign no_tail = (tail_size >= SIZE_W'(4));
  assign no_beat = (exec_state[3:0] != 4'd0);

  always_comb begin
    if (no_tail && no_beat && blk_lo == '0)
      assert_lo_forced_R2: assert (lane_mask[LANES/2-1:0] == '1);
    if (no_tail && no_beat && blk_hi == '0)
      assert_hi_forced_R3: assert (lane_mask[LANES-1:LANES/2] == '1);
    if (tail_size == '0 && loop_cnt == '0)
      assert_zero_count_R4: assert (lane_mask == '0);
    if (no_beat)
      assert_no_flag_R6: assert (!illegal);
    if (!no_beat && exec_state[7:4] == 4'd1)
      assert_one_beat_R7: assert (lane_mask[3:0] == 4'd0);
    if (illegal)
      assert_illegal_zero_R8: assert (lane_mask == '0);
    assert_subset_R9: assert ((lane_mask & ~pred_lanes &
      {{(LANES/2){blk_hi != '0}}, {(LANES/2){blk_lo != '0}}}) == '0);
  end
endmodule

bind pm_lane_mask pm_lane_mask_chk #(
  .LANES(LANES), .BLK_W(BLK_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W), .XS_W(XS_W)
) u_chk (
  .pred_lanes (pred_lanes),
  .blk_lo     (blk_lo),
  .blk_hi     (blk_hi),
  .tail_size  (tail_size),
  .loop_cnt   (loop_cnt),
  .exec_state (exec_state),
  .lane_mask  (lane_mask),
  .illegal    (illegal)
);

// File: tb/sim_pm_lane_mask.sv
module sim_pm_lane_mask;
  logic        clk;
  logic        rst_n;
  logic [15:0] pred_lanes;
  logic [3:0]  blk_lo;
  logic [3:0]  blk_hi;
  logic [2:0]  tail_size;
  logic [31:0] loop_cnt;
  logic [7:0]  exec_state;
  logic [15:0] lane_mask;
  logic        illegal;

  int checks;
  int failures;
  bit done;

  pm_lane_mask u0 (
    .pred_lanes (pred_lanes),
    .blk_lo     (blk_lo),
    .blk_hi     (blk_hi),
    .tail_size  (tail_size),
    .loop_cnt   (loop_cnt),
    .exec_state (exec_state),
    .lane_mask  (lane_mask),
    .illegal    (illegal)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference model written from the requirements
  function automatic logic [16:0] model(input logic [15:0] p, input logic [3:0] lo,
      input logic [3:0] hi, input logic [2:0] sz, input logic [31:0] cnt,
      input logic [7:0] xs);
    logic [15:0] m;
    logic        bad;
    int          n;
    m = p;
    bad = 1'b0;
    if (lo == 0) m[7:0] = 8'hFF;
    if (hi == 0) m[15:8] = 8'hFF;
    if (sz < 4 && cnt <= (32'd16 >> sz)) begin
      n = int'(cnt) << sz;
      for (int i = 0; i < 16; i++) if (i >= n) m[i] = 1'b0;
    end
    if (xs[3:0] == 0) begin
      case (xs[7:4])
        4'd0: ;
        4'd1: m = m & 16'hFFF0;
        4'd2: m = m & 16'hFF00;
        4'd4, 4'd5: m = m & 16'hF000;
        default: begin m = 16'h0; bad = 1'b1; end
      endcase
    end
    return {bad, m};
  endfunction

  task automatic drive(input logic [15:0] p, input logic [3:0] lo, input logic [3:0] hi,
      input logic [2:0] sz, input logic [31:0] cnt, input logic [7:0] xs);
    @(negedge clk);
    pred_lanes = p; blk_lo = lo; blk_hi = hi;
    tail_size = sz; loop_cnt = cnt; exec_state = xs;
    #5;
  endtask

  task automatic expect_out(input string req, input logic [15:0] em, input logic ei);
    checks++;
    if (lane_mask !== em || illegal !== ei) begin
      failures++;
      $display("FAIL %s mask=%h ill=%b expected mask=%h ill=%b", req, lane_mask, illegal, em, ei);
    end
  endtask

  task automatic t_reset_state;
    drive(16'h0, 4'h0, 4'h0, 3'd0, 32'd0, 8'h00);
    expect_out("R4 initial all-zero", 16'h0000, 1'b0);
  endtask

  task automatic t_passthrough;
    drive(16'hA5C3, 4'h8, 4'h4, 3'd4, 32'd0, 8'h01);
    expect_out("R1", 16'hA5C3, 1'b0);
    drive(16'h0000, 4'hF, 4'h1, 3'd7, 32'd3, 8'hF8);
    expect_out("R1 zero pred", 16'h0000, 1'b0);
  endtask

  task automatic t_block_enables;
    drive(16'h1200, 4'h0, 4'h8, 3'd4, 32'd5, 8'h02);
    expect_out("R2", 16'h12FF, 1'b0);
    drive(16'h0034, 4'h2, 4'h0, 3'd5, 32'd5, 8'h02);
    expect_out("R3", 16'hFF34, 1'b0);
  endtask

  task automatic t_tail;
    drive(16'hFFFF, 4'h1, 4'h1, 3'd0, 32'd5, 8'h01);
    expect_out("R4 bytes cnt5", 16'h001F, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd1, 32'd3, 8'h01);
    expect_out("R4 halves cnt3", 16'h003F, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd3, 32'd2, 8'h01);
    expect_out("R4 dwords limit", 16'hFFFF, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd2, 32'd0, 8'h01);
    expect_out("R4 count zero", 16'h0000, 1'b0);
  endtask

  task automatic t_tail_off;
    drive(16'hFFFF, 4'h1, 4'h1, 3'd2, 32'd5, 8'h01);
    expect_out("R5 above limit", 16'hFFFF, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd4, 32'd1, 8'h01);
    expect_out("R5 size off", 16'hFFFF, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd0, 32'h8000_0001, 8'h01);
    expect_out("R5 huge count", 16'hFFFF, 1'b0);
  endtask

  task automatic t_beats;
    drive(16'hFFFF, 4'h1, 4'h1, 3'd4, 32'd0, 8'h37);
    expect_out("R6 cond nonzero", 16'hFFFF, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd4, 32'd0, 8'h10);
    expect_out("R7 one beat", 16'hFFF0, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd4, 32'd0, 8'h20);
    expect_out("R7 two beats", 16'hFF00, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd4, 32'd0, 8'h40);
    expect_out("R7 three beats", 16'hF000, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd4, 32'd0, 8'h50);
    expect_out("R7 three plus", 16'hF000, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd4, 32'd0, 8'h30);
    expect_out("R8 code3", 16'h0000, 1'b1);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd4, 32'd0, 8'hF0);
    expect_out("R8 codeF", 16'h0000, 1'b1);
  endtask

  task automatic t_combined;
    drive(16'hFFFF, 4'h0, 4'h0, 3'd0, 32'd10, 8'h10);
    expect_out("R9 tail+beat1", 16'h03F0, 1'b0);
    drive(16'h0F0F, 4'h0, 4'h1, 3'd1, 32'd7, 8'h20);
    expect_out("R9 tail+beat2+pred", 16'h0F00, 1'b0);
    drive(16'hFFFF, 4'h1, 4'h1, 3'd2, 32'd3, 8'h40);
    expect_out("R9 tail+beat3", 16'h0000, 1'b0);
  endtask

  task automatic t_sweep;
    logic [15:0] pats [3];
    logic [16:0] e;
    pats[0] = 16'hFFFF; pats[1] = 16'h5A3C; pats[2] = 16'h8001;
    for (int p = 0; p < 3; p++)
      for (int lh = 0; lh < 4; lh++)
        for (int sz = 0; sz < 8; sz++)
          for (int c = 0; c < 19; c++)
            for (int x = 0; x < 17; x++) begin
              logic [7:0] xs;
              xs = (x == 16) ? 8'h29 : {4'(x), 4'h0};
              drive(pats[p], (lh[0] ? 4'h6 : 4'h0), (lh[1] ? 4'h9 : 4'h0),
                    3'(sz), 32'(c), xs);
              e = model(pats[p], (lh[0] ? 4'h6 : 4'h0), (lh[1] ? 4'h9 : 4'h0),
                        3'(sz), 32'(c), xs);
              expect_out("R9 sweep", e[15:0], e[16]);
            end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    pred_lanes = '0; blk_lo = '0; blk_hi = '0;
    tail_size = '0; loop_cnt = '0; exec_state = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_passthrough();
    t_block_enables();
    t_tail();
    t_tail_off();
    t_beats();
    t_combined();
    t_sweep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule